// File: doc/BRIEF.md
# Asynchronous SRAM Port Sequencer

This block sits between a simple synchronous request interface and one port of an asynchronous static RAM of 4096 bytes that has no arbitration of its own. A client raises a request with a write flag, a 12-bit address and a byte of write data. The sequencer then drives the chip-enable, read/write and output-enable strobes, the address lines and the data bus drive-enable. Each strobe is held for a number of clock cycles set by parameters, and those counts are derived from the memory's access, pulse, setup, hold and cycle times. When the access completes, the block raises a one-cycle done pulse. On a read, the captured byte appears on the read-data output with that pulse.

Writes are shaped in one of two ways, chosen by a parameter. In the first, chip enable is asserted first and read/write low is the strobe. In the second, read/write falls first and chip enable low is the strobe. A second parameter keeps output enable low during the write. In the read/write-shaped variant this lengthens the strobe, because the memory's own output drivers must turn off before the written data setup time can begin. Between accesses the port is deselected, which puts the memory in standby with its pins at high impedance.

Top module: `sram_port_seq`

## Requirements
- R1: While reset is held, ready_o=1, done_o=0, rdata_o=0, mem_addr_o=0, mem_ce_n_o=1, mem_rw_n_o=1, mem_oe_n_o=1 and mem_dq_oe_o=0.
- R2: ready_o is high exactly in idle. A request is accepted on a rising edge where req_i=1 and ready_o=1. A request raised while ready_o=0 has no effect, and no access is made for it later.
- R3: The write overlap (mem_ce_n_o=0 and mem_rw_n_o=0 together) lasts PW cycles. PW=max(T_WP,T_WZ+T_DW) when SHAPE_BY_CE=0 and OE_LOW_IN_WRITE=1, and PW=max(T_WP,T_DW) otherwise. mem_dq_oe_o=1 with the write byte on mem_dq_o from the first overlap cycle.
- R4: For max(1,T_DH) cycles after the overlap ends, the bus stays driven with the same byte and address, with mem_oe_n_o=1. The bus is then released.
- R5: mem_addr_o changes only on an edge where mem_ce_n_o or mem_rw_n_o is high both before and after the edge. It holds its value for the whole access and through idle.
- R6: With SHAPE_BY_CE=0, chip enable goes low for max(1,T_AS) cycles with mem_rw_n_o=1 before read/write falls, and stays low through the hold cycles while mem_rw_n_o=1. With SHAPE_BY_CE=1, read/write goes low for max(1,T_AS) cycles before chip enable falls, and stays low through the hold cycles while mem_ce_n_o=1.
- R7: A read drives mem_ce_n_o=0, mem_oe_n_o=0 and mem_rw_n_o=1 for ACC=max(T_AA,T_ACE,T_AOE) cycles. It captures mem_dq_i at the end of the last of these cycles and shows the byte on rdata_o from the next cycle until the next read completes.
- R8: mem_dq_oe_o is never 1 while mem_oe_n_o=0 and mem_rw_n_o=1.
- R9: After a read's enable phase, the port is deselected (all strobes high, bus released) for max(1,T_HZ,T_CYC-ACC) cycles. After a write's hold phase it is deselected for max(T_WR,T_CYC-(setup+PW+hold)) cycles, possibly zero. No access keeps ready_o low for fewer than T_CYC cycles.
- R10: In idle the port is deselected: mem_ce_n_o=1, mem_rw_n_o=1, mem_oe_n_o=1 and mem_dq_oe_o=0.
- R11: done_o is high for exactly one cycle per access. For a write this is the last hold cycle. For a read it is the first deselect cycle after the enable phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Word address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | High while idle and able to accept |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | 12 | Memory address lines |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_rw_n_o | output | 1 | Read/write, low = write |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned by the memory |

## Verification
A phase register that leaves a phase too early or too late shows up at the pins in the very cycle it happens. The strobe pattern expected at each sample then differs, and a shortened overlap or access shows as a wrong captured byte, because the memory model returns filler until the access time has elapsed. A wrong latched address or byte is seen on the first strobe cycle. It is seen again when the location is read back, and the expected value there comes from an independent reference store. A busy flag that fails to hold off a request shows as an unexpected access in the cycle right after the original one ends.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WSU   = 3'd1,
        PH_WSTB  = 3'd2,
        PH_WHOLD = 3'd3,
        PH_RACC  = 3'd4,
        PH_REC   = 3'd5
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic rw_n;
        logic oe_n;
        logic drv;
    } pins_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
    assign last    = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_seq_capture.sv
`timescale 1ns/1ps
module sram_seq_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = cap ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/sram_port_seq.sv
`timescale 1ns/1ps
module sram_port_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W          = 12,
    parameter int DATA_W          = 8,
    parameter bit SHAPE_BY_CE     = 1'b0,
    parameter bit OE_LOW_IN_WRITE = 1'b0,
    parameter int T_AS            = 0,
    parameter int T_WP            = 2,
    parameter int T_DW            = 2,
    parameter int T_WZ            = 2,
    parameter int T_DH            = 1,
    parameter int T_WR            = 0,
    parameter int T_AA            = 3,
    parameter int T_ACE           = 3,
    parameter int T_AOE           = 2,
    parameter int T_HZ            = 2,
    parameter int T_CYC           = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_rw_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Phase lengths in cycles
    localparam int SU_N   = imax(1, T_AS);
    localparam int PW_N   = (!SHAPE_BY_CE && OE_LOW_IN_WRITE) ? imax(T_WP, T_WZ + T_DW)
                                                              : imax(T_WP, T_DW);
    localparam int HOLD_N = imax(1, T_DH);
    localparam int WBODY  = SU_N + PW_N + HOLD_N;
    localparam int WREC_N = imax(0, imax(T_WR, T_CYC - WBODY));
    localparam int ACC_N  = imax(imax(T_AA, T_ACE), T_AOE);
    localparam int RREC_N = imax(1, imax(T_HZ, T_CYC - ACC_N));
    localparam int MAXN   = imax(imax(imax(SU_N, PW_N), imax(HOLD_N, WREC_N)),
                                 imax(ACC_N, RREC_N));
    localparam int CNT_W  = $clog2(MAXN + 1);

    typedef struct packed {
        phase_e            ph;
        logic              ready;
        logic              done;
        pins_t             pins;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  t_load, t_exp, t_last, cap;
    logic [CNT_W-1:0] t_val;

    function automatic pins_t decode(phase_e ph);
        pins_t p;
        p = '{ce_n: 1'b1, rw_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        case (ph)
            PH_WSU: begin
                p.ce_n = SHAPE_BY_CE;
                p.rw_n = !SHAPE_BY_CE;
                p.oe_n = !OE_LOW_IN_WRITE;
            end
            PH_WSTB: begin
                p.ce_n = 1'b0;
                p.rw_n = 1'b0;
                p.oe_n = !OE_LOW_IN_WRITE;
                p.drv  = 1'b1;
            end
            PH_WHOLD: begin
                p.ce_n = SHAPE_BY_CE;
                p.rw_n = !SHAPE_BY_CE;
                p.drv  = 1'b1;
            end
            PH_RACC: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        cap    = 1'b0;
        r_d.done = 1'b0;
        case (r_q.ph)
            PH_IDLE: if (req_i) begin
                r_d.addr  = addr_i;
                r_d.wdata = wdata_i;
                t_load    = 1'b1;
                if (we_i) begin
                    r_d.ph = PH_WSU;
                    t_val  = CNT_W'(SU_N - 1);
                end else begin
                    r_d.ph = PH_RACC;
                    t_val  = CNT_W'(ACC_N - 1);
                end
            end
            PH_WSU: if (t_exp) begin
                r_d.ph = PH_WSTB;
                t_load = 1'b1;
                t_val  = CNT_W'(PW_N - 1);
            end
            PH_WSTB: if (t_exp) begin
                r_d.ph   = PH_WHOLD;
                t_load   = 1'b1;
                t_val    = CNT_W'(HOLD_N - 1);
                r_d.done = (HOLD_N == 1);
            end
            PH_WHOLD: begin
                if (t_exp) begin
                    if (WREC_N > 0) begin
                        r_d.ph = PH_REC;
                        t_load = 1'b1;
                        t_val  = CNT_W'(imax(WREC_N, 1) - 1);
                    end else begin
                        r_d.ph = PH_IDLE;
                    end
                end else if (t_last) begin
                    r_d.done = 1'b1;
                end
            end
            PH_RACC: if (t_exp) begin
                r_d.ph   = PH_REC;
                t_load   = 1'b1;
                t_val    = CNT_W'(RREC_N - 1);
                cap      = 1'b1;
                r_d.done = 1'b1;
            end
            PH_REC: if (t_exp) r_d.ph = PH_IDLE;
            default: r_d.ph = PH_IDLE;
        endcase
        r_d.pins  = decode(r_d.ph);
        r_d.ready = (r_d.ph == PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph    <= PH_IDLE;
            r_q.ready <= 1'b1;
            r_q.done  <= 1'b0;
            r_q.pins  <= '{ce_n: 1'b1, rw_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            r_q.addr  <= '0;
            r_q.wdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .expired(t_exp), .last(t_last)
    );

    sram_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(mem_dq_i), .dout(rdata_o)
    );

    assign ready_o     = r_q.ready;
    assign done_o      = r_q.done;
    assign mem_addr_o  = r_q.addr;
    assign mem_ce_n_o  = r_q.pins.ce_n;
    assign mem_rw_n_o  = r_q.pins.rw_n;
    assign mem_oe_n_o  = r_q.pins.oe_n;
    assign mem_dq_oe_o = r_q.pins.drv;
    assign mem_dq_o    = r_q.wdata;

    // Checker state: overlap length and busy length
    logic        olap;
    logic [15:0] olap_cnt, busy_cnt;
    assign olap = !mem_ce_n_o && !mem_rw_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            olap_cnt <= '0;
            busy_cnt <= '0;
        end else begin
            olap_cnt <= olap ? olap_cnt + 16'd1 : 16'd0;
            busy_cnt <= ready_o ? 16'd0 : busy_cnt + 16'd1;
        end
    end

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(olap) |-> (olap_cnt == 16'(PW_N)));

    assert_hold_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(olap) |-> (mem_dq_oe_o && mem_oe_n_o && $stable(mem_dq_o) && $stable(mem_addr_o)));

    assert_addr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr_o) |-> (($past(mem_ce_n_o) || $past(mem_rw_n_o)) && (mem_ce_n_o || mem_rw_n_o)));

    assert_no_bus_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> !(!mem_oe_n_o && mem_rw_n_o));

    assert_cycle_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (busy_cnt >= 16'(T_CYC)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    generate
        if (SHAPE_BY_CE) begin : g_ce_shape
            assert_ce_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(mem_ce_n_o) && !mem_rw_n_o) |-> $past(!mem_rw_n_o));
        end else begin : g_rw_shape
            assert_rw_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(mem_rw_n_o) |-> (!mem_ce_n_o && $past(!mem_ce_n_o)));
        end
    endgenerate
endmodule

// File: tb/sram_port_seq_test.sv
`timescale 1ns/1ps
module sram_port_seq_test;

    localparam int AS = 0, WP = 2, DW = 2, WZ = 2, DH = 1, WR = 0;
    localparam int AA = 3, ACE = 3, AOE = 2, HZ = 2;

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [7:0] fill(logic [11:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    typedef struct packed {
        logic       rdy;
        logic       dn;
        logic       ce;
        logic       rw;
        logic       oe;
        logic       drv;
        logic [11:0] a;
        logic [7:0] d;
        logic       rdv;
        logic [7:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  rdy_v;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int g,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cfg%0d: actual %0h expected %0h", tag, g, act, exp);
        end
    endtask

    for (genvar g = 0; g < 3; g++) begin : cfg
        localparam int SHP  = (g == 2) ? 1 : 0;
        localparam int OEW  = (g >= 1) ? 1 : 0;
        localparam int CYC  = (g == 2) ? 6 : 3;
        localparam int SU   = mx(1, AS);
        localparam int PW   = (SHP == 0 && OEW == 1) ? mx(WP, WZ + DW) : mx(WP, DW);
        localparam int HOLD = mx(1, DH);
        localparam int WREC = mx(0, mx(WR, CYC - (SU + PW + HOLD)));
        localparam int ACC  = mx(mx(AA, ACE), AOE);
        localparam int RREC = mx(1, mx(HZ, CYC - ACC));

        logic        rdy, dn, ce, rw, oe, doe;
        logic [11:0] ma;
        logic [7:0]  mdo, rd;
        logic [7:0]  mdi = 8'h5A;

        sram_port_seq #(
            .SHAPE_BY_CE(SHP[0]), .OE_LOW_IN_WRITE(OEW[0]),
            .T_AS(AS), .T_WP(WP), .T_DW(DW), .T_WZ(WZ), .T_DH(DH), .T_WR(WR),
            .T_AA(AA), .T_ACE(ACE), .T_AOE(AOE), .T_HZ(HZ), .T_CYC(CYC)
        ) uut (
            .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
            .wdata_i(wdata), .ready_o(rdy), .done_o(dn), .rdata_o(rd),
            .mem_addr_o(ma), .mem_ce_n_o(ce), .mem_rw_n_o(rw), .mem_oe_n_o(oe),
            .mem_dq_o(mdo), .mem_dq_oe_o(doe), .mem_dq_i(mdi)
        );

        assign rdy_v[g] = rdy;

        bit [7:0]    sram [int];
        bit [7:0]    refm [int];
        exp_t        q[$];
        bit          idle_seen = 1'b0;
        logic [11:0] last_a = '0;
        logic [7:0]  exp_rd = '0;
        int          rd_cnt = 0;

        // Reference: on acceptance, queue the expected pin values per cycle
        always @(posedge clk) begin
            if (!rst_n) begin
                q.delete();
                idle_seen = 1'b0;
            end else if (idle_seen && req) begin
                exp_t e;
                idle_seen = 1'b0;
                last_a = addr;
                if (we) begin
                    for (int i = 0; i < SU; i++) begin
                        e = '{1'b0, 1'b0, SHP[0], ~SHP[0], ~OEW[0], 1'b0, addr, wdata, 1'b0, 8'h00};
                        q.push_back(e);
                    end
                    for (int i = 0; i < PW; i++) begin
                        e = '{1'b0, 1'b0, 1'b0, 1'b0, ~OEW[0], 1'b1, addr, wdata, 1'b0, 8'h00};
                        q.push_back(e);
                    end
                    for (int i = 0; i < HOLD; i++) begin
                        e = '{1'b0, (i == HOLD - 1), SHP[0], ~SHP[0], 1'b1, 1'b1, addr, wdata, 1'b0, 8'h00};
                        q.push_back(e);
                    end
                    for (int i = 0; i < WREC; i++) begin
                        e = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, addr, wdata, 1'b0, 8'h00};
                        q.push_back(e);
                    end
                    refm[int'(addr)] = wdata;
                end else begin
                    logic [7:0] v;
                    v = refm.exists(int'(addr)) ? refm[int'(addr)] : fill(addr);
                    for (int i = 0; i < ACC; i++) begin
                        e = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, addr, 8'h00, 1'b0, 8'h00};
                        q.push_back(e);
                    end
                    for (int i = 0; i < RREC; i++) begin
                        e = '{1'b0, (i == 0), 1'b1, 1'b1, 1'b1, 1'b0, addr, 8'h00, (i == 0), v};
                        q.push_back(e);
                    end
                end
            end
        end

        // Compare every cycle; the memory model reacts to the pins
        always @(negedge clk) begin
            if (!rst_n) begin
                if (cyc >= 2) begin
                    chk(rdy && !dn && ce && rw && oe && !doe && ma == 12'h0 && rd == 8'h00,
                        "R1 reset state", g, {rdy, dn, ce, rw, oe, doe, ma, rd},
                        {6'b101110, 12'h0, 8'h00});
                end
                rd_cnt = 0;
                mdi    = 8'h5A;
            end else begin
                exp_t e;
                if (q.size() > 0) begin
                    e = q.pop_front();
                    idle_seen = 1'b0;
                end else begin
                    e = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, last_a, 8'h00, 1'b0, 8'h00};
                    idle_seen = 1'b1;
                end
                chk(rdy == e.rdy, "R2 ready", g, 32'(rdy), 32'(e.rdy));
                chk(dn == e.dn, "R11 done", g, 32'(dn), 32'(e.dn));
                chk(ce == e.ce && rw == e.rw, "R6 R9 R10 strobes", g,
                    32'({ce, rw}), 32'({e.ce, e.rw}));
                chk(oe == e.oe, "R7 R4 output enable", g, 32'(oe), 32'(e.oe));
                chk(doe == e.drv, "R3 R4 R8 drive", g, 32'(doe), 32'(e.drv));
                chk(ma == e.a, "R5 address", g, 32'(ma), 32'(e.a));
                if (e.drv) chk(mdo == e.d, "R3 write byte", g, 32'(mdo), 32'(e.d));
                if (e.rdv) exp_rd = e.rd;
                chk(rd == exp_rd, "R7 read data", g, 32'(rd), 32'(exp_rd));

                if (!ce && !rw && doe) sram[int'(ma)] = mdo;
                if (!ce && !oe && rw) rd_cnt++;
                else                  rd_cnt = 0;
                if (rd_cnt >= ACC)
                    mdi = sram.exists(int'(ma)) ? sram[int'(ma)] : fill(ma);
                else
                    mdi = 8'h5A;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (rdy_v != 3'b111);
    endtask

    task automatic op(input bit w, input logic [11:0] a, input logic [7:0] d,
                      input bit intrude);
        wait_idle();
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        if (intrude) begin
            // R2: a request while busy must leave no trace
            we = 1'b1; addr = 12'h0BB; wdata = 8'h44;
            @(negedge clk);
        end
        req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op(1, 12'h000, 8'h11, 0);
        op(1, 12'hFFF, 8'hEE, 0);
        op(1, 12'h5A3, 8'h3C, 0);
        op(0, 12'h000, 8'h00, 0);
        op(0, 12'hFFF, 8'h00, 0);
        op(0, 12'h5A3, 8'h00, 0);
        op(0, 12'h123, 8'h00, 0);
        op(1, 12'h123, 8'h77, 0);
        op(0, 12'h123, 8'h00, 0);
        op(1, 12'h0AA, 8'h99, 1);
        op(0, 12'h0BB, 8'h00, 1);
        op(0, 12'h0AA, 8'h00, 0);
        for (int i = 0; i < 16; i++)
            op(1, 12'(i * 257 + 3), 8'(i * 29 + 1), 0);
        for (int i = 0; i < 16; i++)
            op(0, 12'(i * 257 + 3), 8'h00, 0);
        wait_idle();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule